// File: doc/BRIEF.md
# Keyboard Activity Hold Detector

This block turns the traffic on a keyboard's two-wire serial link into one steady "key active" level in the system clock domain. The link's clock and data wires are asynchronous to the system clock, so each passes through a chain of system-clock registers before any logic looks at it. Every transition of the synchronized link clock, whether rising or falling, reloads a down-counter. The active level is high while that counter is nonzero. A frame's clock burst therefore appears as one unbroken pulse. The pulse ends a fixed hold time after the last link clock transition.

The hold time is set by two parameters, the system clock in kHz and the hold time in microseconds. The default is 50 us, which is half of the slowest link clock period. For a downstream frame receiver, the block also provides a one-cycle strobe on each falling edge of the link clock, together with the synchronized data bit that goes with it. Decoding of the received bytes is done outside this block.

Top module: `ps2_key_hold`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after it, `key_held_o` and `ps2_fall_o` are 0 and `ps2_dat_o` is 1, the idle level of the link.
- R2: After system clock edge n, `ps2_dat_o` equals the value of `ps2_dat_i` sampled at edge n-2. This means two synchronizing stages and no use of a singly registered copy.
- R3: A change of `ps2_clk_i` first sampled at edge k reloads the hold counter, and `key_held_o` is high after edge k+2. Rising and falling changes have the same effect.
- R4: Without a further link clock change, `key_held_o` stays high for exactly RELOAD cycles and is low from edge k+2+RELOAD on. RELOAD = CLK_KHZ*TIMEOUT_US/1000.
- R5: A link clock change arriving while the counter runs restarts the full hold time. With changes sampled exactly RELOAD cycles apart, the reload wins over expiry and `key_held_o` shows no low cycle between them.
- R6: With changes sampled RELOAD+1 cycles apart, `key_held_o` drops for exactly one cycle in each gap.
- R7: `ps2_fall_o` is a one-cycle pulse after edge n only when `ps2_clk_i` sampled at n-3 was 1 and at n-2 was 0. It stays low for rising changes.
- R8: Changes on `ps2_dat_i` alone never raise `key_held_o`.
- R9: With `ps2_clk_i` idling high after reset, `key_held_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Link clock wire, asynchronous |
| ps2_dat_i | input | 1 | Link data wire, asynchronous |
| key_held_o | output | 1 | High while link clock activity was seen within the hold time |
| ps2_fall_o | output | 1 | One-cycle strobe on each link clock falling edge |
| ps2_dat_o | output | 1 | Synchronized data bit, aligned with the strobe |

## Verification
A counter that reloads late, decrements wrongly or misses its priority over expiry shows up on `key_held_o`. The fault appears as a high pulse of the wrong length or as a one-cycle dropout inside a burst. It becomes visible no later than RELOAD+2 cycles after the offending link clock change. A synchronizer chain of the wrong depth shifts `ps2_dat_o`, the strobe and the start of the held level by whole cycles. This is caught within three cycles of any input change. A stale edge register either produces a strobe on a rising change or lets data-wire activity hold the output high.

// File: rtl/ps2_hold_pkg.sv
package ps2_hold_pkg;

  localparam logic LINE_IDLE = 1'b1;

  function automatic int unsigned hold_cycles(input int unsigned clk_khz,
                                              input int unsigned hold_us);
    int unsigned c;
    c = (clk_khz * hold_us) / 1000;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d,
  output logic [STAGES-1:0] q
);

  // q[0] is the newest sample; q[STAGES-1] the oldest
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q[g] <= RST_VAL;
          else     q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q[g] <= RST_VAL;
          else     q[g] <= q[g-1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ps2h_edge.sv
module ps2h_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_new,
  input  logic clk_old,
  input  logic dat_sync,
  output logic any_edge,
  output logic fall_q,
  output logic dat_q
);
  import ps2_hold_pkg::*;

  logic fall_c;

  assign any_edge = clk_new ^ clk_old;
  assign fall_c   = ~clk_new & clk_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
      dat_q  <= LINE_IDLE;
    end else begin
      fall_q <= fall_c;
      dat_q  <= dat_sync;
    end
  end

endmodule

// File: rtl/ps2h_timer.sv
module ps2h_timer #(
  parameter int unsigned RELOAD = 6250,
  parameter int unsigned CW     = $clog2(RELOAD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reload,
  output logic [CW-1:0] cnt,
  output logic          held
);

  logic [CW-1:0] cnt_nxt;

  // reload has priority over reaching zero
  always_comb begin
    if (reload)         cnt_nxt = CW'(RELOAD);
    else if (cnt != '0) cnt_nxt = cnt - CW'(1);
    else                cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      held <= (cnt_nxt != '0);
    end
  end

endmodule

// File: rtl/ps2_key_hold.sv
module ps2_key_hold #(
  parameter int unsigned CLK_KHZ    = 125000,
  parameter int unsigned TIMEOUT_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic key_held_o,
  output logic ps2_fall_o,
  output logic ps2_dat_o
);
  import ps2_hold_pkg::*;

  localparam int unsigned RELOAD  = hold_cycles(CLK_KHZ, TIMEOUT_US);
  localparam int unsigned CW      = $clog2(RELOAD + 1);
  localparam int unsigned CLK_STG = 3;
  localparam int unsigned DAT_STG = 2;

  logic [CLK_STG-1:0] clk_pipe;
  logic [DAT_STG-1:0] dat_pipe;
  logic               any_edge;
  logic [CW-1:0]      tmr_cnt;

  ps2h_sync #(.STAGES(CLK_STG), .RST_VAL(LINE_IDLE)) u_clk_sync (
    .clk(clk), .rst(rst), .d(ps2_clk_i), .q(clk_pipe)
  );

  ps2h_sync #(.STAGES(DAT_STG), .RST_VAL(LINE_IDLE)) u_dat_sync (
    .clk(clk), .rst(rst), .d(ps2_dat_i), .q(dat_pipe)
  );

  // only stages 1 and 2 (already synchronized) feed the edge logic
  ps2h_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .clk_new  (clk_pipe[1]),
    .clk_old  (clk_pipe[2]),
    .dat_sync (dat_pipe[1]),
    .any_edge (any_edge),
    .fall_q   (ps2_fall_o),
    .dat_q    (ps2_dat_o)
  );

  ps2h_timer #(.RELOAD(RELOAD), .CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .reload (any_edge),
    .cnt    (tmr_cnt),
    .held   (key_held_o)
  );

endmodule

// File: rtl/ps2_key_hold_chk.sv
module ps2_key_hold_chk #(
  parameter int unsigned CLK_KHZ    = 125000,
  parameter int unsigned TIMEOUT_US = 50,
  localparam int unsigned RELOAD = ps2_hold_pkg::hold_cycles(CLK_KHZ, TIMEOUT_US),
  localparam int unsigned CW     = $clog2(RELOAD + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          held,
  input logic          fall,
  input logic [CW-1:0] cnt
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!held && !fall));

  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

  // R3
  fall_implies_held_chk: assert property (@(posedge clk) disable iff (rst)
    fall |-> held);

  // R4
  full_count_held_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(RELOAD)) |-> held);

  // R4
  drop_after_one_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> ($past(cnt) == CW'(1)));

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(cnt) != '0) && (cnt != CW'(RELOAD))) |-> (cnt == $past(cnt) - CW'(1)));

endmodule

bind ps2_key_hold ps2_key_hold_chk #(
  .CLK_KHZ(CLK_KHZ), .TIMEOUT_US(TIMEOUT_US)
) u_chk (
  .clk(clk), .rst(rst), .held(key_held_o), .fall(ps2_fall_o), .cnt(tmr_cnt)
);

// File: tb/test_ps2_key_hold.sv
module test_ps2_key_hold;

  localparam int CLK_KHZ    = 1000;
  localparam int TIMEOUT_US = 50;
  localparam int RELOAD     = CLK_KHZ * TIMEOUT_US / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ps2_clk_i = 1'b1;
  logic ps2_dat_i = 1'b1;
  logic key_held_o, ps2_fall_o, ps2_dat_o;

  int checks = 0;
  int errors = 0;
  int lows   = 0;
  bit win    = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ps2_key_hold #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_US(TIMEOUT_US)) i_ps2_key_hold (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .key_held_o(key_held_o), .ps2_fall_o(ps2_fall_o), .ps2_dat_o(ps2_dat_o)
  );

  // ---------------- behavioural reference model ----------------
  bit cs[$];   // link clock samples, one per system clock edge
  bit ds[$];   // link data samples
  int eq[$];   // cycles where a link clock change was first sampled
  bit rsts[$];
  bit exp_held, exp_fall, exp_dat, model_on;

  initial begin
    repeat (3) begin cs.push_back(1'b1); ds.push_back(1'b1); rsts.push_back(1'b1); end
  end

  always @(posedge clk) begin
    int n;
    if (rst) begin
      cs.push_back(1'b1); ds.push_back(1'b1); eq.delete();
    end else begin
      cs.push_back(ps2_clk_i); ds.push_back(ps2_dat_i);
    end
    rsts.push_back(rst);
    n = cs.size() - 1;
    if (cs[n] != cs[n-1]) eq.push_back(n);
    while (eq.size() > 1 && eq[1] <= n - 2) void'(eq.pop_front());
    exp_held = 1'b0;
    if (eq.size() > 0 && eq[0] <= n - 2 && n - eq[0] <= RELOAD + 1) exp_held = 1'b1;
    if (rst) exp_held = 1'b0;
    exp_fall = !rst && (cs[n-2] == 1'b0) && (cs[n-3] == 1'b1);
    exp_dat  = rst ? 1'b1 : ds[n-2];
    model_on = 1'b1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !done) begin
      check("R4 held vs model", key_held_o, exp_held);
      check("R7 fall strobe vs model", ps2_fall_o, exp_fall);
      check("R2 sync data vs model", ps2_dat_o, exp_dat);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      if (win) lows += (key_held_o ? 0 : 1);
    end
  endtask

  task automatic spaced_toggles(input int cnt, input int gap, input int exp_lows, input string req);
    lows = 0;
    for (int i = 0; i < cnt; i++) begin
      ps2_clk_i = ~ps2_clk_i;
      if (i == 0) begin step(3); win = 1'b1; step(gap - 3); end
      else if (i < cnt - 1) step(gap);
    end
    step(3);
    win = 1'b0;
    checks++;
    if (lows != exp_lows) begin
      errors++;
      $display("FAIL %s low cycles actual=%0d expected=%0d", req, lows, exp_lows);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    int hi;
    step(5);
    // R1 reset state
    check("R1 held in reset", key_held_o, 1'b0);
    check("R1 fall in reset", ps2_fall_o, 1'b0);
    check("R1 data in reset", ps2_dat_o, 1'b1);
    rst = 1'b0;
    step(1);
    check("R1 held after reset", key_held_o, 1'b0);

    // R9 idle line keeps output low
    step(30);
    check("R9 idle held", key_held_o, 1'b0);

    // R8 data-only activity
    for (int i = 0; i < 8; i++) begin ps2_dat_i = ~ps2_dat_i; step(3); end
    ps2_dat_i = 1'b1;
    step(5);
    check("R8 data toggles ignored", key_held_o, 1'b0);

    // R3 single falling change: held appears after third edge
    ps2_clk_i = 1'b0;
    step(2);
    check("R3 not yet held", key_held_o, 1'b0);
    step(1);
    check("R3 held after k+2", key_held_o, 1'b1);
    check("R7 fall strobe on falling", ps2_fall_o, 1'b1);
    // R4 count held duration
    hi = 1;
    for (int i = 0; i < RELOAD + 10; i++) begin step(1); if (key_held_o) hi++; end
    checks++;
    if (hi != RELOAD) begin
      errors++;
      $display("FAIL R4 held length actual=%0d expected=%0d", hi, RELOAD);
    end

    // R3 / R7 rising change: held again, no strobe
    ps2_clk_i = 1'b1;
    step(3);
    check("R3 held on rising", key_held_o, 1'b1);
    check("R7 no strobe on rising", ps2_fall_o, 1'b0);
    step(RELOAD + 5);

    // frame-like burst: 11 bits, half period 20 cycles, varying data (R2, R7)
    for (int b = 0; b < 11; b++) begin
      ps2_dat_i = ((8'hA6 >> (b % 8)) & 1) != 0;
      step(10);
      ps2_clk_i = 1'b0;
      step(20);
      ps2_clk_i = 1'b1;
      step(10);
    end
    check("R5 held through burst", key_held_o, 1'b1);
    step(RELOAD + 5);
    check("R4 released after burst", key_held_o, 1'b0);

    // R5 boundary: gap exactly RELOAD -> no dropout
    spaced_toggles(4, RELOAD, 0, "R5");
    step(RELOAD + 5);
    // R6 gap RELOAD+1 -> one dropout per gap
    spaced_toggles(4, RELOAD + 1, 3, "R6");
    step(RELOAD + 5);

    // R1 mid-run reset while held
    ps2_clk_i = ~ps2_clk_i;
    step(4);
    ps2_clk_i = 1'b1;
    step(4);
    check("R3 held before reset", key_held_o, 1'b1);
    rst = 1'b1;
    step(1);
    check("R1 held cleared by reset", key_held_o, 1'b0);
    step(2);
    rst = 1'b0;
    step(10);
    check("R1 stays low after reset", key_held_o, 1'b0);

    finish_run();
  end

endmodule